// File: doc/BRIEF.md
# Dual-Channel Capture/Compare Mode Control

This block holds the 32-bit mode word for a two-channel general-purpose timer and turns it into per-channel routing. Software writes and reads the word over a simple address-decoded bus. The word sits at offset 0x18. Each channel has an 8-bit slice in the low half-word and one extra mode bit in the upper half. Every other upper bit is reserved. These reserved bits ignore writes and always read back as zero.

Each channel has a 2-bit direction code. The code makes the channel an output, or an input taken from one of three sources: the channel's own pin, the other channel's pin, or the internal trigger line. The internal trigger only drives a channel when the slave-mode logic reports that an internal trigger source is selected. While a channel is enabled, its direction code is frozen, but the rest of the word still takes writes. A per-channel clear-enable bit lets an external clear input force that channel's raw compare reference low. This happens in the same cycle the clear input is high.

Top module: `ccmode_ctrl`

## Requirements
- R1: After reset the stored word reads back as 0x0000_0000, both channels report output mode, both routed capture inputs are 0, and each gated reference equals its raw reference.
- R2: Only bits 24, 16 and 15:0 are writable. Writing 0xFFFF_FFFF reads back 0x0101_FFFF, and writing 0xFEFE_0000 reads back 0x0000_0000.
- R3: A write with bus_wr high and bus_addr equal to 0x18 stores the data, and the new value is readable on the next cycle. A write to any other address changes nothing. bus_rdata is zero unless bus_rd is high and bus_addr is 0x18.
- R4: Direction codes sit at bits 1:0 (channel 1) and 9:8 (channel 2). While ch_en[c] is 1, a write leaves channel c's code unchanged, and all other writable bits still update.
- R5: ch_is_out[c] is 1 exactly when channel c's direction code is 00. Bit 0 of each vector is channel 1 and bit 1 is channel 2.
- R6: Code 01 routes the channel's own pin to cap_in[c] (ti1 for channel 1, ti2 for channel 2). Code 10 routes the other channel's pin.
- R7: Code 11 routes trc to cap_in[c] when trig_internal is 1, and holds cap_in[c] at 0 when trig_internal is 0.
- R8: A channel in output mode (code 00) holds cap_in[c] at 0 whatever the pins do.
- R9: With the channel's clear-enable bit at 0 (bit 7 for channel 1, bit 15 for channel 2), oc_ref[c] equals oc_ref_raw[c] regardless of ref_clr.
- R10: With the clear-enable bit at 1, oc_ref[c] is 0 in any cycle where ref_clr is 1. When ref_clr returns to 0, oc_ref[c] follows oc_ref_raw[c] again in the same cycle.
- R11: The two channels are configured independently. Channel 1 can capture from its pin while channel 2 is an output with its own clear setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, zero when not selected |
| ch_en | input | 2 | Channel enable; locks the direction code |
| trig_internal | input | 1 | Slave-mode trigger selection is an internal source |
| ti1 | input | 1 | Channel 1 pin input |
| ti2 | input | 1 | Channel 2 pin input |
| trc | input | 1 | Internal trigger input |
| oc_ref_raw | input | 2 | Raw compare reference per channel |
| ref_clr | input | 1 | Reference clear input |
| cap_in | output | 2 | Routed capture input per channel |
| oc_ref | output | 2 | Gated compare reference per channel |
| ch_is_out | output | 2 | Channel is in output mode |

## Verification
The stored word is the only state. A corrupted bit shows on bus_rdata at the first read. It also shows within the same cycle at the combinational outputs: a wrong direction code changes ch_is_out and the cap_in source, and a wrong clear-enable bit changes whether oc_ref drops under ref_clr. A write lock that fails shows as a changed direction code on the readback right after a write made while the channel was enabled. Each routing source is driven through all pin combinations, so a swapped or stuck route gives a cap_in mismatch at once.

// File: rtl/ccmode_pkg.sv
package ccmode_pkg;

    localparam int NCH       = 2;
    localparam int DATA_W    = 32;
    localparam int CH_STRIDE = 8;
    localparam int SEL_W     = 2;
    localparam int CLR_OFS   = 7;
    localparam int MODE_HI0  = 16;

    typedef enum logic [SEL_W-1:0] {
        SEL_OUT = 2'b00,
        SEL_OWN = 2'b01,
        SEL_NBR = 2'b10,
        SEL_TRG = 2'b11
    } dir_sel_e;

    function automatic int sel_lsb(input int ch);
        return ch * CH_STRIDE;
    endfunction

    function automatic int clr_bit(input int ch);
        return ch * CH_STRIDE + CLR_OFS;
    endfunction

    function automatic int mode_hi_bit(input int ch);
        return MODE_HI0 + ch * CH_STRIDE;
    endfunction

    function automatic logic [DATA_W-1:0] wr_mask();
        logic [DATA_W-1:0] m;
        m = '0;
        for (int c = 0; c < NCH; c++) begin
            for (int b = 0; b < CH_STRIDE; b++) begin
                m[c*CH_STRIDE + b] = 1'b1;
            end
            m[mode_hi_bit(c)] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/ccmode_regs.sv
module ccmode_regs
    import ccmode_pkg::*;
#(
    parameter int              ADDR_W  = 8,
    parameter logic [ADDR_W-1:0] REG_OFS = 8'h18
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr,
    input  logic                  rd,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [DATA_W-1:0]     wdata,
    input  logic [NCH-1:0]        ch_en,
    output logic [DATA_W-1:0]     rdata,
    output logic [NCH*SEL_W-1:0]  sel_q,
    output logic [NCH-1:0]        clr_en_q
);

    localparam logic [DATA_W-1:0] MASK = wr_mask();

    typedef struct packed {
        logic [DATA_W-1:0] cfg;
    } regs_t;

    regs_t state_d, state_q;
    logic  hit;

    assign hit = (addr == REG_OFS);

    always_comb begin
        state_d = state_q;
        if (wr && hit) begin
            state_d.cfg = wdata & MASK;
            for (int c = 0; c < NCH; c++) begin
                if (ch_en[c]) begin
                    state_d.cfg[c*CH_STRIDE +: SEL_W] = state_q.cfg[c*CH_STRIDE +: SEL_W];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign rdata = (rd && hit) ? state_q.cfg : '0;

    for (genvar c = 0; c < NCH; c++) begin : g_fields
        assign sel_q[c*SEL_W +: SEL_W] = state_q.cfg[c*CH_STRIDE +: SEL_W];
        assign clr_en_q[c]             = state_q.cfg[c*CH_STRIDE + CLR_OFS];
    end

endmodule

// File: rtl/ccmode_inmux.sv
module ccmode_inmux
    import ccmode_pkg::*;
(
    input  logic [SEL_W-1:0] sel,
    input  logic             own_pin,
    input  logic             nbr_pin,
    input  logic             trc,
    input  logic             trig_internal,
    output logic             cap,
    output logic             is_out
);

    always_comb begin
        cap    = 1'b0;
        is_out = 1'b0;
        unique case (dir_sel_e'(sel))
            SEL_OUT: is_out = 1'b1;
            SEL_OWN: cap    = own_pin;
            SEL_NBR: cap    = nbr_pin;
            SEL_TRG: cap    = trig_internal & trc;
            default: cap    = 1'b0;
        endcase
    end

endmodule

// File: rtl/ccmode_refclr.sv
module ccmode_refclr (
    input  logic clr_en,
    input  logic ref_raw,
    input  logic clr,
    output logic ref_out
);

    logic kill;

    always_comb begin
        kill    = clr_en & clr;
        ref_out = ref_raw & ~kill;
    end

endmodule

// File: rtl/ccmode_ctrl.sv
module ccmode_ctrl
    import ccmode_pkg::*;
#(
    parameter int              ADDR_W  = 8,
    parameter logic [ADDR_W-1:0] REG_OFS = 8'h18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [1:0]        ch_en,
    input  logic              trig_internal,
    input  logic              ti1,
    input  logic              ti2,
    input  logic              trc,
    input  logic [1:0]        oc_ref_raw,
    input  logic              ref_clr,
    output logic [1:0]        cap_in,
    output logic [1:0]        oc_ref,
    output logic [1:0]        ch_is_out
);

    logic [NCH*SEL_W-1:0] ch_sel;
    logic [NCH-1:0]       ch_clr_en;
    logic [NCH-1:0]       pins;

    assign pins = {ti2, ti1};

    ccmode_regs #(
        .ADDR_W (ADDR_W),
        .REG_OFS(REG_OFS)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (bus_wr),
        .rd      (bus_rd),
        .addr    (bus_addr),
        .wdata   (bus_wdata),
        .ch_en   (ch_en),
        .rdata   (bus_rdata),
        .sel_q   (ch_sel),
        .clr_en_q(ch_clr_en)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        ccmode_inmux u_mux (
            .sel          (ch_sel[c*SEL_W +: SEL_W]),
            .own_pin      (pins[c]),
            .nbr_pin      (pins[NCH-1-c]),
            .trc          (trc),
            .trig_internal(trig_internal),
            .cap          (cap_in[c]),
            .is_out       (ch_is_out[c])
        );

        ccmode_refclr u_clr (
            .clr_en (ch_clr_en[c]),
            .ref_raw(oc_ref_raw[c]),
            .clr    (ref_clr),
            .ref_out(oc_ref[c])
        );
    end

endmodule

// File: rtl/ccmode_ctrl_chk.sv
module ccmode_ctrl_chk #(
    parameter int              ADDR_W  = 8,
    parameter logic [ADDR_W-1:0] REG_OFS = 8'h18
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [1:0]        ch_en,
    input logic              trig_internal,
    input logic [1:0]        oc_ref_raw,
    input logic              ref_clr,
    input logic [1:0]        cap_in,
    input logic [1:0]        oc_ref,
    input logic [1:0]        ch_is_out,
    input logic [3:0]        ch_sel,
    input logic [1:0]        ch_clr_en
);

    logic wr_hit;
    assign wr_hit = bus_wr && (bus_addr == REG_OFS);

    a_r3_no_stray_write: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_hit |=> $stable(ch_sel) && $stable(ch_clr_en));

    for (genvar c = 0; c < 2; c++) begin : g_chk
        a_r4_sel_locked: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_hit && ch_en[c]) |=> ch_sel[2*c +: 2] == $past(ch_sel[2*c +: 2]));

        a_r5_out_flag: assert property (@(posedge clk) disable iff (!rst_n)
            ch_is_out[c] == (ch_sel[2*c +: 2] == 2'b00));

        a_r7_trc_gated: assert property (@(posedge clk) disable iff (!rst_n)
            (!trig_internal && ch_sel[2*c +: 2] == 2'b11) |-> !cap_in[c]);

        a_r8_out_no_cap: assert property (@(posedge clk) disable iff (!rst_n)
            ch_is_out[c] |-> !cap_in[c]);

        a_r9_ref_pass: assert property (@(posedge clk) disable iff (!rst_n)
            !ch_clr_en[c] |-> oc_ref[c] == oc_ref_raw[c]);

        a_r10_ref_cleared: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_clr_en[c] && ref_clr) |-> !oc_ref[c]);
    end

endmodule

bind ccmode_ctrl ccmode_ctrl_chk #(
    .ADDR_W (ADDR_W),
    .REG_OFS(REG_OFS)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_wr       (bus_wr),
    .bus_addr     (bus_addr),
    .ch_en        (ch_en),
    .trig_internal(trig_internal),
    .oc_ref_raw   (oc_ref_raw),
    .ref_clr      (ref_clr),
    .cap_in       (cap_in),
    .oc_ref       (oc_ref),
    .ch_is_out    (ch_is_out),
    .ch_sel       (ch_sel),
    .ch_clr_en    (ch_clr_en)
);

// File: tb/ccmode_ctrl_bench.sv
module ccmode_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [1:0]  ch_en = 2'b00;
    logic        trig_internal = 1'b0;
    logic        ti1 = 1'b0;
    logic        ti2 = 1'b0;
    logic        trc = 1'b0;
    logic [1:0]  oc_ref_raw = 2'b00;
    logic        ref_clr = 1'b0;
    logic [1:0]  cap_in;
    logic [1:0]  oc_ref;
    logic [1:0]  ch_is_out;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    ccmode_ctrl u_ccmode_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ch_en(ch_en), .trig_internal(trig_internal), .ti1(ti1), .ti2(ti2),
        .trc(trc), .oc_ref_raw(oc_ref_raw), .ref_clr(ref_clr),
        .cap_in(cap_in), .oc_ref(oc_ref), .ch_is_out(ch_is_out)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = 8'h00; bus_wdata = '0;
    endtask

    task automatic rd_reg(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        bus_rd = 1'b0; bus_addr = 8'h00;
    endtask

    task automatic settle();
        #1;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd_reg(8'h18, d);
        check("R1 word", d, 32'h0);
        check("R1 out flags", {30'b0, ch_is_out}, 32'h3);
        check("R1 cap", {30'b0, cap_in}, 32'h0);
        oc_ref_raw = 2'b10; settle();
        check("R1 ref", {30'b0, oc_ref}, 32'h2);
        oc_ref_raw = 2'b00;
    endtask

    task automatic t_reserved();
        logic [31:0] d;
        wr_reg(8'h18, 32'hFFFF_FFFF);
        rd_reg(8'h18, d);
        check("R2 all ones", d, 32'h0101_FFFF);
        wr_reg(8'h18, 32'hFEFE_0000);
        rd_reg(8'h18, d);
        check("R2 reserved only", d, 32'h0);
    endtask

    task automatic t_decode();
        logic [31:0] d;
        wr_reg(8'h18, 32'h0000_A5A5);
        rd_reg(8'h18, d);
        check("R3 store", d, 32'h0000_A5A5);
        wr_reg(8'h1C, 32'h0000_FFFF);
        rd_reg(8'h18, d);
        check("R3 other addr write", d, 32'h0000_A5A5);
        rd_reg(8'h1C, d);
        check("R3 other addr read", d, 32'h0);
        @(negedge clk); settle();
        check("R3 no rd", bus_rdata, 32'h0);
    endtask

    task automatic t_lock();
        logic [31:0] d;
        wr_reg(8'h18, 32'h0000_0303);
        ch_en = 2'b01;
        wr_reg(8'h18, 32'h0000_0080);
        rd_reg(8'h18, d);
        check("R4 ch1 locked", d, 32'h0000_0083);
        ch_en = 2'b11;
        wr_reg(8'h18, 32'hFFFF_FFFF);
        rd_reg(8'h18, d);
        check("R4 both locked", d, 32'h0101_FCFF);
        ch_en = 2'b00;
    endtask

    task automatic t_outflag();
        wr_reg(8'h18, 32'h0000_0100); settle();
        check("R5 ch1 out", {30'b0, ch_is_out}, 32'h1);
        wr_reg(8'h18, 32'h0000_0001); settle();
        check("R5 ch2 out", {30'b0, ch_is_out}, 32'h2);
    endtask

    task automatic t_pins();
        wr_reg(8'h18, 32'h0000_0201);
        for (int k = 0; k < 4; k++) begin
            ti1 = k[0]; ti2 = k[1]; settle();
            check("R6 own/nbr", {30'b0, cap_in}, {30'b0, ti1, ti1});
        end
        wr_reg(8'h18, 32'h0000_0102);
        for (int k = 0; k < 4; k++) begin
            ti1 = k[0]; ti2 = k[1]; settle();
            check("R6 nbr/own", {30'b0, cap_in}, {30'b0, ti2, ti2});
        end
        ti1 = 1'b0; ti2 = 1'b0;
    endtask

    task automatic t_trc();
        wr_reg(8'h18, 32'h0000_0303);
        trig_internal = 1'b1; trc = 1'b1; settle();
        check("R7 trc high", {30'b0, cap_in}, 32'h3);
        trc = 1'b0; settle();
        check("R7 trc low", {30'b0, cap_in}, 32'h0);
        trig_internal = 1'b0; trc = 1'b1; settle();
        check("R7 not internal", {30'b0, cap_in}, 32'h0);
        trc = 1'b0;
    endtask

    task automatic t_outidle();
        wr_reg(8'h18, 32'h0000_0000);
        ti1 = 1'b1; ti2 = 1'b1; trc = 1'b1; trig_internal = 1'b1; settle();
        check("R8 out idle", {30'b0, cap_in}, 32'h0);
        ti1 = 1'b0; ti2 = 1'b0; trc = 1'b0; trig_internal = 1'b0;
    endtask

    task automatic t_refclr();
        wr_reg(8'h18, 32'h0000_0000);
        ref_clr = 1'b1; oc_ref_raw = 2'b11; settle();
        check("R9 pass both", {30'b0, oc_ref}, 32'h3);
        oc_ref_raw = 2'b01; settle();
        check("R9 pass one", {30'b0, oc_ref}, 32'h1);
        ref_clr = 1'b0;
        wr_reg(8'h18, 32'h0000_0080);
        oc_ref_raw = 2'b11; ref_clr = 1'b1; settle();
        check("R10 ch1 cleared", {30'b0, oc_ref}, 32'h2);
        ref_clr = 1'b0; settle();
        check("R10 released", {30'b0, oc_ref}, 32'h3);
        wr_reg(8'h18, 32'h0000_8080);
        ref_clr = 1'b1; settle();
        check("R10 both cleared", {30'b0, oc_ref}, 32'h0);
        ref_clr = 1'b0; oc_ref_raw = 2'b00;
    endtask

    task automatic t_indep();
        wr_reg(8'h18, 32'h0000_8001);
        ti1 = 1'b1; oc_ref_raw = 2'b11; ref_clr = 1'b1; settle();
        check("R11 cap", {30'b0, cap_in}, 32'h1);
        check("R11 out flags", {30'b0, ch_is_out}, 32'h2);
        check("R11 ref", {30'b0, oc_ref}, 32'h1);
        ti1 = 1'b0; oc_ref_raw = 2'b00; ref_clr = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_reserved();
        t_decode();
        t_lock();
        t_outflag();
        t_pins();
        t_trc();
        t_outidle();
        t_refclr();
        t_indep();
        repeat (2) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule